// File: doc/BRIEF.md
# Sleep Entry and Wake Status Controller

This block holds the sleep-entry and wake-status logic of a power-management controller. Software reaches it through a small register bus with a write strobe, an address and a byte of write data, and a combinational read-data return. It has four registers: a configuration byte, a sleep control register, a status register and a wake-event enable mask. A write that sets the sleep "go" bit either issues a one-cycle sleep request carrying a sleep type, or, when the configuration asks for it, is trapped into a system-management interrupt (SMI) request instead.

A sticky wake-status flag records a falling edge on the active-low power-button input. That input is resynchronised inside the block. When the configuration widens the wake sources, the flag is also set by any external wake event whose enable bit is set. A configuration bit also selects the clock source for an external infrared wake detector. The configuration byte, the wake enables and the wake flag sit in the battery-backed domain and keep their values across an ordinary system reset.

Register map (address : contents): 0 = configuration, 1 = sleep control, 2 = status, 3 = wake enable.

Top module: `pm_sleep_wake`

## Requirements
- R1: The configuration register (address 0) reads 0x00 after a battery power-on reset (`vbat_por_n` low). A system reset (`rst_n` low) leaves it unchanged.
- R2: Only configuration bits 0 (SMI redirect), 1 (wide wake) and 7 (PLL clock) are stored. Bits 6..2 always read zero.
- R3: With configuration bit 0 clear, a write to address 1 with bit 7 set gives `sleep_req` high for exactly the one cycle after the write edge. `sleep_type` then equals bits 2..0 of that same write, and bits 2..0 read back at address 1.
- R4: With configuration bit 0 set, the same write gives no `sleep_req`, and `smi_req` goes high from the cycle after the write.
- R5: Status bit 1 (sleep SMI status) is set by every write of 1 to bit 7 of address 1, whatever configuration bit 0 holds. `smi_req` is status bit 1 AND configuration bit 0.
- R6: A write to address 1 with bit 7 clear raises no `sleep_req` and does not change status bit 1.
- R7: Status bit 0 (`wake_sts`) is set once per falling edge of `pwr_on_n`, on the third clock edge after the input falls (two synchroniser flops, then an edge register). A steady low level does not set it again.
- R8: With configuration bit 1 set, a wake event whose enable bit (address 3) is set sets `wake_sts` on the next edge. A disabled event, or any event while bit 1 is clear, has no effect.
- R9: Status bits clear when 1 is written to their position at address 2. A set condition in the same cycle wins over the clear.
- R10: `ir_clk_sel` equals configuration bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| vbat_por_n | input | 1 | Battery-domain power-on reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address (write and read) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| pwr_on_n | input | 1 | Active-low power-button input, asynchronous |
| wake_evt | input | NUM_WAKE | Wake event levels, synchronous |
| sleep_req | output | 1 | One-cycle sleep request |
| sleep_type | output | TYPE_W | Sleep type of the latest sleep control write |
| smi_req | output | 1 | SMI request for a trapped sleep write |
| wake_sts | output | 1 | Sticky wake-status flag |
| ir_clk_sel | output | 1 | Selects the PLL-derived clock for the infrared wake detector |

## Verification
The hardest situation to reach is a set condition and a write-one-to-clear landing on the same edge. For the wake flag, the stimulus holds an enabled wake event steady with wide wake on and then clears the flag, so that the event and the clear meet on one edge. The bench also holds `pwr_on_n` low across several cycles after a clear, to show that one edge sets the flag only once. A system reset is applied after the configuration has been loaded, to show that the battery-domain state survives it. A random phase then mixes register writes, button toggles and wake events, all against the reference model.

// File: rtl/pm_sw_pkg.sv
package pm_sw_pkg;
   // register addresses
   localparam int unsigned REG_CFG  = 0;
   localparam int unsigned REG_CTL  = 1;
   localparam int unsigned REG_STAT = 2;
   localparam int unsigned REG_WEN  = 3;
   // configuration bit positions
   localparam int unsigned CFG_REDIR = 0;
   localparam int unsigned CFG_WIDE  = 1;
   localparam int unsigned CFG_PLL   = 7;
   localparam logic [7:0]  CFG_MASK  = 8'h83;
   // control and status bit positions
   localparam int unsigned CTL_GO    = 7;
   localparam int unsigned STAT_WAKE = 0;
   localparam int unsigned STAT_SMI  = 1;
endpackage

// File: rtl/pm_sw_sync_fall.sv
module pm_sw_sync_fall #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pm_sw_sync_fall: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         last_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign fall = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/pm_sw_sticky.sv
module pm_sw_sticky #(
   parameter int unsigned W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/pm_sw_mask_reg.sv
module pm_sw_mask_reg #(
   parameter int unsigned  W    = 8,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & MASK;
   end
endmodule

// File: rtl/pm_sw_sleep_ctl.sv
module pm_sw_sleep_ctl #(
   parameter int unsigned TYPE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic              go_bit,
   input  logic [TYPE_W-1:0] type_in,
   input  logic              redirect,
   output logic              go_wr,
   output logic              sleep_req,
   output logic [TYPE_W-1:0] sleep_type
);
   assign go_wr = ctl_we & go_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleep_req  <= 1'b0;
         sleep_type <= '0;
      end else begin
         sleep_req <= go_wr & ~redirect;
         if (ctl_we) sleep_type <= type_in;
      end
   end
endmodule

// File: rtl/pm_sleep_wake.sv
module pm_sleep_wake
   import pm_sw_pkg::*;
#(
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned NUM_WAKE    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TYPE_W      = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                vbat_por_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [7:0]          wr_data,
   output logic [7:0]          rd_data,
   input  logic                pwr_on_n,
   input  logic [NUM_WAKE-1:0] wake_evt,
   output logic                sleep_req,
   output logic [TYPE_W-1:0]   sleep_type,
   output logic                smi_req,
   output logic                wake_sts,
   output logic                ir_clk_sel
);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(REG_CFG);
   localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(REG_CTL);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
   localparam logic [ADDR_W-1:0] A_WEN  = ADDR_W'(REG_WEN);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("pm_sleep_wake: ADDR_W must be at least 2");
      end
      if (NUM_WAKE < 1 || NUM_WAKE > 8) begin : g_bad_wake
         $error("pm_sleep_wake: NUM_WAKE must be 1..8");
      end
      if (TYPE_W < 1 || TYPE_W > 7) begin : g_bad_type
         $error("pm_sleep_wake: TYPE_W must be 1..7");
      end
   endgenerate

   logic                cfg_we, ctl_we, stat_we, wen_we;
   logic [7:0]          cfg_q;
   logic [NUM_WAKE-1:0] wen_q;
   logic                go_wr, pwr_fall, wake_hit;
   logic                smi_sts;

   assign cfg_we  = wr_en && (addr == A_CFG);
   assign ctl_we  = wr_en && (addr == A_CTL);
   assign stat_we = wr_en && (addr == A_STAT);
   assign wen_we  = wr_en && (addr == A_WEN);

   // battery-domain configuration and wake enables
   pm_sw_mask_reg #(.W(8), .MASK(CFG_MASK)) u_cfg (
      .clk(clk), .rst_n(vbat_por_n), .we(cfg_we), .wdata(wr_data), .q(cfg_q));

   pm_sw_mask_reg #(.W(NUM_WAKE), .MASK({NUM_WAKE{1'b1}})) u_wen (
      .clk(clk), .rst_n(vbat_por_n), .we(wen_we),
      .wdata(wr_data[NUM_WAKE-1:0]), .q(wen_q));

   pm_sw_sleep_ctl #(.TYPE_W(TYPE_W)) u_sleep (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .go_bit(wr_data[CTL_GO]),
      .type_in(wr_data[TYPE_W-1:0]), .redirect(cfg_q[CFG_REDIR]),
      .go_wr(go_wr), .sleep_req(sleep_req), .sleep_type(sleep_type));

   pm_sw_sync_fall #(.STAGES(SYNC_STAGES)) u_pwr (
      .clk(clk), .rst_n(rst_n), .din(pwr_on_n), .fall(pwr_fall));

   assign wake_hit = cfg_q[CFG_WIDE] & (|(wake_evt & wen_q));

   pm_sw_sticky #(.W(1)) u_wake_sts (
      .clk(clk), .rst_n(vbat_por_n),
      .set(pwr_fall | wake_hit),
      .clr(stat_we & wr_data[STAT_WAKE]),
      .q(wake_sts));

   pm_sw_sticky #(.W(1)) u_smi_sts (
      .clk(clk), .rst_n(rst_n),
      .set(go_wr),
      .clr(stat_we & wr_data[STAT_SMI]),
      .q(smi_sts));

   assign smi_req    = smi_sts & cfg_q[CFG_REDIR];
   assign ir_clk_sel = cfg_q[CFG_PLL];

   always_comb begin
      rd_data = 8'h00;
      if (addr == A_CFG)       rd_data = cfg_q;
      else if (addr == A_CTL)  rd_data = 8'(sleep_type);
      else if (addr == A_STAT) begin
         rd_data[STAT_WAKE] = wake_sts;
         rd_data[STAT_SMI]  = smi_sts;
      end
      else if (addr == A_WEN)  rd_data = 8'(wen_q);
   end
endmodule

// File: rtl/pm_sleep_wake_chk.sv
module pm_sleep_wake_chk #(
   parameter int unsigned ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vbat_por_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic              go_bit,
   input logic              w1c_wake,
   input logic [4:0]        rd_rsv,
   input logic              redirect,
   input logic              smi_sts,
   input logic              sleep_req,
   input logic              smi_req,
   input logic              wake_sts
);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);

   // R3: a sleep request only follows an untrapped go write
   a_r3_sleep_needs_go: assert property (@(posedge clk) disable iff (!rst_n || !vbat_por_n)
      sleep_req |-> $past(wr_en && addr == A_CTL && go_bit && !redirect));

   // R4: the SMI request needs the redirect bit
   a_r4_smi_needs_redirect: assert property (@(posedge clk) disable iff (!rst_n || !vbat_por_n)
      smi_req |-> redirect);

   // R5: every go write sets the sleep SMI status
   a_r5_go_sets_smi_sts: assert property (@(posedge clk) disable iff (!rst_n || !vbat_por_n)
      (wr_en && addr == A_CTL && go_bit) |=> smi_sts);

   // R6: a control write with go clear requests no sleep
   a_r6_zero_go_no_sleep: assert property (@(posedge clk) disable iff (!rst_n || !vbat_por_n)
      (wr_en && addr == A_CTL && !go_bit) |=> !sleep_req);

   // R9: wake status holds unless cleared
   a_r9_wake_sticky: assert property (@(posedge clk) disable iff (!vbat_por_n)
      (wake_sts && !(wr_en && addr == A_STAT && w1c_wake)) |=> wake_sts);

   // R2: reserved configuration bits read zero
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n || !vbat_por_n)
      (addr == A_CFG) |-> (rd_rsv == 5'b0));
endmodule

bind pm_sleep_wake pm_sleep_wake_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .vbat_por_n(vbat_por_n), .wr_en(wr_en), .addr(addr),
   .go_bit(wr_data[7]), .w1c_wake(wr_data[0]), .rd_rsv(rd_data[6:2]),
   .redirect(cfg_q[0]), .smi_sts(smi_sts), .sleep_req(sleep_req),
   .smi_req(smi_req), .wake_sts(wake_sts));

// File: tb/pm_sleep_wake_tb.sv
module pm_sleep_wake_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0, vbat_por_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       pwr_on_n = 1'b1;
   logic [3:0] wake_evt = 4'h0;
   logic       sleep_req, smi_req, wake_sts, ir_clk_sel;
   logic [2:0] sleep_type;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pm_sleep_wake u_dut (
      .clk(clk), .rst_n(rst_n), .vbat_por_n(vbat_por_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .pwr_on_n(pwr_on_n), .wake_evt(wake_evt),
      .sleep_req(sleep_req), .sleep_type(sleep_type), .smi_req(smi_req),
      .wake_sts(wake_sts), .ir_clk_sel(ir_clk_sel));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [7:0] m_cfg = 0;
   logic [3:0] m_wen = 0;
   logic       m_wake = 0, m_smi = 0, m_req = 0;
   logic [2:0] m_type = 0;
   logic       p1 = 1, p2 = 1, p3 = 1;

   always @(posedge clk) begin
      logic [7:0] cfg_old;
      logic fall, hit, go, clr_w, clr_s;
      cfg_old = m_cfg;
      fall  = p3 & ~p2;
      hit   = cfg_old[1] & (|(wake_evt & m_wen));
      go    = wr_en && addr == 2'd1 && wr_data[7];
      clr_w = wr_en && addr == 2'd2 && wr_data[0];
      clr_s = wr_en && addr == 2'd2 && wr_data[1];
      if (!vbat_por_n) begin
         m_cfg = 0; m_wen = 0; m_wake = 0;
      end else begin
         if (fall || hit) m_wake = 1;
         else if (clr_w)  m_wake = 0;
         if (wr_en && addr == 2'd0) m_cfg = wr_data & 8'h83;
         if (wr_en && addr == 2'd3) m_wen = wr_data[3:0];
      end
      if (!rst_n) begin
         m_smi = 0; m_req = 0; m_type = 0; p1 = 1; p2 = 1; p3 = 1;
      end else begin
         m_req = go && !cfg_old[0];
         if (wr_en && addr == 2'd1) m_type = wr_data[2:0];
         if (go) m_smi = 1;
         else if (clr_s) m_smi = 0;
         p3 = p2; p2 = p1; p1 = pwr_on_n;
      end
      #1;
      if (!done) begin
         logic [7:0] exp_rd;
         case (addr)
            2'd0:    exp_rd = m_cfg;
            2'd1:    exp_rd = {5'b0, m_type};
            2'd2:    exp_rd = {6'b0, m_smi, m_wake};
            default: exp_rd = {4'b0, m_wen};
         endcase
         chk("R3 model sleep_req", {7'b0, sleep_req}, {7'b0, m_req});
         chk("R3 model sleep_type", {5'b0, sleep_type}, {5'b0, m_type});
         chk("R4 R5 model smi_req", {7'b0, smi_req}, {7'b0, m_smi & m_cfg[0]});
         chk("R7 R8 R9 model wake_sts", {7'b0, wake_sts}, {7'b0, m_wake});
         chk("R10 model ir_clk_sel", {7'b0, ir_clk_sel}, {7'b0, m_cfg[7]});
         chk("R2 model rd_data", rd_data, exp_rd);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1; addr = a; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      addr = a; #1; v = rd_data;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      idle(3);
      vbat_por_n = 1; rst_n = 1;
      idle(1);
      rd(2'd0, v); chk("R1 cfg after battery reset", v, 8'h00);
      chk("R3 sleep_req after reset", {7'b0, sleep_req}, 8'h00);

      wr(2'd0, 8'hFF);
      rd(2'd0, v); chk("R2 reserved bits read zero", v, 8'h83);
      chk("R10 clk select follows bit 7", {7'b0, ir_clk_sel}, 8'h01);

      @(negedge clk); rst_n = 0; idle(2); rst_n = 1; idle(1);
      rd(2'd0, v); chk("R1 cfg survives system reset", v, 8'h83);

      wr(2'd0, 8'h00);
      chk("R10 clk select cleared", {7'b0, ir_clk_sel}, 8'h00);
      wr(2'd1, 8'h85);
      chk("R3 sleep_req pulse", {7'b0, sleep_req}, 8'h01);
      chk("R3 sleep_type latched", {5'b0, sleep_type}, 8'h05);
      chk("R5 no smi without redirect", {7'b0, smi_req}, 8'h00);
      rd(2'd2, v); chk("R5 smi status set regardless", v, 8'h02);
      idle(1);
      chk("R3 sleep_req single cycle", {7'b0, sleep_req}, 8'h00);

      wr(2'd1, 8'h03);
      chk("R6 go clear gives no sleep", {7'b0, sleep_req}, 8'h00);
      rd(2'd2, v); chk("R6 status unchanged", v, 8'h02);
      rd(2'd1, v); chk("R3 type readback", v, 8'h03);

      wr(2'd2, 8'h02);
      rd(2'd2, v); chk("R9 smi status cleared", v, 8'h00);
      wr(2'd0, 8'h01);
      wr(2'd1, 8'h82);
      chk("R4 trapped: no sleep_req", {7'b0, sleep_req}, 8'h00);
      chk("R4 trapped: smi_req high", {7'b0, smi_req}, 8'h01);
      wr(2'd2, 8'h02);
      chk("R9 smi_req drops after clear", {7'b0, smi_req}, 8'h00);

      wr(2'd0, 8'h00);
      @(negedge clk); pwr_on_n = 0;
      idle(2);
      chk("R7 not yet set after two edges", {7'b0, wake_sts}, 8'h00);
      idle(1);
      chk("R7 set on third edge", {7'b0, wake_sts}, 8'h01);
      wr(2'd2, 8'h01);
      idle(5);
      chk("R7 level low sets only once", {7'b0, wake_sts}, 8'h00);
      pwr_on_n = 1; idle(4);

      wr(2'd3, 8'h05);
      wr(2'd0, 8'h02);
      wake_evt = 4'h2; idle(2);
      chk("R8 disabled event ignored", {7'b0, wake_sts}, 8'h00);
      wake_evt = 4'h4; idle(1);
      chk("R8 enabled event sets wake", {7'b0, wake_sts}, 8'h01);
      wr(2'd2, 8'h01);
      chk("R9 set wins over clear", {7'b0, wake_sts}, 8'h01);
      wake_evt = 4'h0;
      wr(2'd2, 8'h01);
      chk("R9 clear without set", {7'b0, wake_sts}, 8'h00);
      wr(2'd0, 8'h00);
      wake_evt = 4'h4; idle(2);
      chk("R8 event ignored when narrow", {7'b0, wake_sts}, 8'h00);
      wake_evt = 4'h0;

      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         wr_en    = ($urandom_range(0, 2) == 0);
         addr     = 2'($urandom_range(0, 3));
         wr_data  = 8'($urandom);
         wake_evt = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
         if ($urandom_range(0, 9) == 0) pwr_on_n = ~pwr_on_n;
      end
      @(negedge clk); wr_en = 0;
      idle(2);
      finish_run();
   end
endmodule